// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is a synthesizable model of a parallel NOR flash that follows the classic two-step unlock command protocol. A host on a simple synchronous bus presents a byte address, a write strobe with write data, or a read strobe. The storage lives in on-chip registers and starts fully erased (every byte 0xFF). Plain writes never reach the array. Every write is first judged by a sequencer that expects a handshake at two programmable word addresses. Only once the handshake succeeds does it accept a command for programming, erasing, identification or the query table.

Programming can only clear bits. An erase sets a sector or the whole chip back to 0xFF and then holds the device busy for a parameterised number of clock cycles. During that time writes are ignored and reads return a polling status byte. A fast-path bypass mode lets a host issue commands without repeating the handshake. The data width is 1, 2 or 4 bytes. A parameter selects whether the byte at the lowest address sits in the least or the most significant lane.

Top module: `nor_flash_model`

## Requirements
- R1: After reset the read data output is 0, busy is low, and every array byte reads as 0xFF. Read data is registered: it changes only on the clock edge that samples a read strobe, and it is valid from the following cycle.
- R2: A command is accepted only after 0xAA is written at word address UNLOCK_A and then 0x55 at UNLOCK_B. The command byte itself must then land at UNLOCK_A. A wrong address or data at any of these steps returns the device to array read.
- R3: Command 0xA0 makes the next write a program: each addressed byte becomes old AND new. With BIG_ENDIAN=0, the byte at the lowest address comes from wdata[7:0].
- R4: A write of data 0xF0 returns the device to its idle state from any pending step. The exception is the program-data step, where 0xF0 is stored as ordinary program data.
- R5: Command 0x80 followed by a second unlock pair and data 0x30 at any address erases only the sector that holds that address. All other sectors keep their contents.
- R6: The same sequence ending in data 0x10 at UNLOCK_A erases the whole chip. If 0x10 lands at any other address, nothing is erased.
- R7: A sector erase holds busy high for exactly SECTOR_ERASE_CYC cycles and a chip erase for CHIP_ERASE_CYC cycles. Writes during busy are ignored, and the device returns to its idle state afterwards.
- R8: A read during busy returns a status byte whose bit 7 is 0. Bit 6 starts at 0 for each erase and inverts after every busy read, so the first two reads give 0x00 then 0x40.
- R9: Command 0x90 enters identification mode. Word index 0 reads MFR_ID, word index 1 reads DEV_ID, and word index 2 reads 0x00 (not protected).
- R10: Data 0x98 at word address QUERY_ADDR enters query mode, either from array read or from identification mode. Reads return table byte [word index]: 0x10..0x12 hold "QRY" (0x51 0x52 0x59), 0x27 holds log2 of the chip size, and 0x2D holds the sector count minus one. Indices at or above 0x34 read 0. Any write leaves query mode.
- R11: Command 0x20 enters bypass. In bypass, commands are taken at any address with no handshake. Writing 0x90 then 0x00 leaves bypass.
- R12: Addresses wrap modulo the chip size: upper address bits are ignored.
- R13: Command addresses are compared as word indices, meaning the byte address shifted right by log2(WIDTH_BYTES) and taken within the sector. Any byte of the matching word therefore qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | BUS_ADDR_W | Byte address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8*WIDTH_BYTES | Write data; the command byte is bits 7:0 |
| rdata | output | 8*WIDTH_BYTES | Registered read data |
| busy | output | 1 | High while an erase is running |

## Verification
The assertions assume that read and write strobes are never raised in the same cycle. They also assume that both erase lengths are at least two cycles and differ from each other, so a busy run of either length identifies its erase. The stimulus issues each bus operation as a single-cycle strobe with a cycle of idle between operations. The status-toggle property relies on back-to-back busy reads, which this stimulus never produces, so bit-6 toggling is checked by the bench's reads instead.

// File: rtl/nor_pkg.sv
package nor_pkg;

    typedef enum logic [3:0] {
        M_READ,
        M_UNL1,
        M_CMD,
        M_PROG,
        M_ER0,
        M_ER1,
        M_ERCMD,
        M_IDENT,
        M_QUERY,
        M_BUSY
    } seq_mode_e;

    typedef struct packed {
        logic prog;
        logic chip_clr;
        logic sect_clr;
    } store_op_t;

    localparam logic [7:0] K_KEY_A   = 8'hAA;
    localparam logic [7:0] K_KEY_B   = 8'h55;
    localparam logic [7:0] K_RESET   = 8'hF0;
    localparam logic [7:0] K_PROG    = 8'hA0;
    localparam logic [7:0] K_ERASE   = 8'h80;
    localparam logic [7:0] K_CHIP    = 8'h10;
    localparam logic [7:0] K_SECT    = 8'h30;
    localparam logic [7:0] K_IDENT   = 8'h90;
    localparam logic [7:0] K_BYPASS  = 8'h20;
    localparam logic [7:0] K_QUERY   = 8'h98;
    localparam logic [7:0] K_BYP_OFF = 8'h00;

    localparam logic [7:0] QUERY_LEN = 8'h34;

    function automatic logic [7:0] query_byte(input logic [7:0] idx,
                                              input int chip_log2,
                                              input int sectors,
                                              input int sector_bytes,
                                              input int width_log2);
        logic [7:0] v;
        case (idx)
            8'h10:   v = 8'h51;
            8'h11:   v = 8'h52;
            8'h12:   v = 8'h59;
            8'h13:   v = 8'h02;
            8'h15:   v = 8'h31;
            8'h27:   v = 8'(chip_log2);
            8'h28:   v = 8'(width_log2);
            8'h2C:   v = 8'h01;
            8'h2D:   v = 8'(sectors - 1);
            8'h2E:   v = 8'((sectors - 1) >> 8);
            8'h2F:   v = 8'(sector_bytes >> 8);
            8'h30:   v = 8'(sector_bytes >> 16);
            8'h31:   v = 8'h50;
            8'h32:   v = 8'h52;
            8'h33:   v = 8'h49;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_pkg::*;
#(
    parameter int SWW              = 4,
    parameter int UNLOCK_A         = 5,
    parameter int UNLOCK_B         = 10,
    parameter int QUERY_ADDR       = 5,
    parameter int SECTOR_ERASE_CYC = 20,
    parameter int CHIP_ERASE_CYC   = 200
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic           rd,
    input  logic [7:0]     cmd,
    input  logic [SWW-1:0] sect_word,
    output seq_mode_e      mode,
    output store_op_t      op,
    output logic           busy,
    output logic [7:0]     status
);

    localparam int MAXC  = (CHIP_ERASE_CYC > SECTOR_ERASE_CYC) ? CHIP_ERASE_CYC : SECTOR_ERASE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    localparam logic [SWW-1:0] AT_A = SWW'(UNLOCK_A);
    localparam logic [SWW-1:0] AT_B = SWW'(UNLOCK_B);
    localparam logic [SWW-1:0] AT_Q = SWW'(QUERY_ADDR);

    seq_mode_e        nxt;
    logic             bypass, nbypass;
    logic [CNT_W-1:0] cnt, load_val;
    logic             load;
    seq_mode_e        idle;
    logic             at_a, at_b, at_q;

    assign idle = bypass ? M_CMD : M_READ;
    assign at_a = (sect_word == AT_A);
    assign at_b = (sect_word == AT_B);
    assign at_q = (sect_word == AT_Q);

    always_comb begin
        nxt      = mode;
        nbypass  = bypass;
        op       = '0;
        load     = 1'b0;
        load_val = '0;
        if (mode == M_BUSY) begin
            if (cnt == CNT_W'(1)) nxt = idle;
        end else if (wr) begin
            if (cmd == K_RESET && mode != M_PROG) begin
                nxt = idle;
            end else begin
                case (mode)
                    M_READ: begin
                        if (at_q && cmd == K_QUERY)      nxt = M_QUERY;
                        else if (at_a && cmd == K_KEY_A) nxt = M_UNL1;
                        else                             nxt = M_READ;
                    end
                    M_UNL1:  nxt = (at_b && cmd == K_KEY_B) ? M_CMD : M_READ;
                    M_CMD: begin
                        if (!bypass && !at_a) begin
                            nxt = idle;
                        end else begin
                            case (cmd)
                                K_PROG:   nxt = M_PROG;
                                K_ERASE:  nxt = M_ER0;
                                K_IDENT:  nxt = M_IDENT;
                                K_BYPASS: begin
                                    nbypass = 1'b1;
                                    nxt     = M_CMD;
                                end
                                default:  nxt = idle;
                            endcase
                        end
                    end
                    M_PROG: begin
                        op.prog = 1'b1;
                        nxt     = idle;
                    end
                    M_ER0:   nxt = (at_a && cmd == K_KEY_A) ? M_ER1 : idle;
                    M_ER1:   nxt = (at_b && cmd == K_KEY_B) ? M_ERCMD : idle;
                    M_ERCMD: begin
                        if (cmd == K_CHIP && at_a) begin
                            op.chip_clr = 1'b1;
                            load        = 1'b1;
                            load_val    = CNT_W'(CHIP_ERASE_CYC);
                            nxt         = M_BUSY;
                        end else if (cmd == K_SECT) begin
                            op.sect_clr = 1'b1;
                            load        = 1'b1;
                            load_val    = CNT_W'(SECTOR_ERASE_CYC);
                            nxt         = M_BUSY;
                        end else begin
                            nxt = idle;
                        end
                    end
                    M_IDENT: begin
                        if (bypass && cmd == K_BYP_OFF) begin
                            nbypass = 1'b0;
                            nxt     = M_READ;
                        end else if (at_q && cmd == K_QUERY) begin
                            nxt = M_QUERY;
                        end else begin
                            nxt = idle;
                        end
                    end
                    default: nxt = idle;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= M_READ;
            bypass <= 1'b0;
            cnt    <= '0;
            status <= 8'h00;
        end else begin
            mode   <= nxt;
            bypass <= nbypass;
            if (load) begin
                cnt    <= load_val;
                status <= 8'h00;
            end else begin
                if (mode == M_BUSY && cnt != '0) cnt <= cnt - CNT_W'(1);
                if (mode == M_BUSY && rd) status[6] <= ~status[6];
            end
        end
    end

    assign busy = (mode == M_BUSY);

endmodule

// File: rtl/nor_store.sv
module nor_store
    import nor_pkg::*;
#(
    parameter int WIDTH_BYTES  = 2,
    parameter int SECTOR_BYTES = 32,
    parameter int CHIP_BYTES   = 128,
    parameter bit BIG_ENDIAN   = 1'b0
) (
    input  logic                            clk,
    input  logic                            rst,
    input  store_op_t                       op,
    input  logic [$clog2(CHIP_BYTES)-1:0]   chip_addr,
    input  logic [8*WIDTH_BYTES-1:0]        wdata,
    output logic [8*WIDTH_BYTES-1:0]        rword
);

    localparam int CAW = $clog2(CHIP_BYTES);
    localparam logic [CAW-1:0] WORD_MASK = ~CAW'(WIDTH_BYTES - 1);
    localparam logic [CAW-1:0] SECT_MASK = ~CAW'(SECTOR_BYTES - 1);

    logic [7:0]     mem [CHIP_BYTES];
    logic [CAW-1:0] base, sect_base;

    assign base      = chip_addr & WORD_MASK;
    assign sect_base = chip_addr & SECT_MASK;

    always_ff @(posedge clk) begin
        if (rst || op.chip_clr) begin
            for (int j = 0; j < CHIP_BYTES; j++) mem[j] <= 8'hFF;
        end else if (op.sect_clr) begin
            for (int j = 0; j < CHIP_BYTES; j++)
                if ((CAW'(j) & SECT_MASK) == sect_base) mem[j] <= 8'hFF;
        end else if (op.prog) begin
            for (int i = 0; i < WIDTH_BYTES; i++)
                mem[base + CAW'(i)] <= mem[base + CAW'(i)]
                    & wdata[8*(BIG_ENDIAN ? (WIDTH_BYTES - 1 - i) : i) +: 8];
        end
    end

    for (genvar g = 0; g < WIDTH_BYTES; g++) begin : g_lane
        localparam int POS = BIG_ENDIAN ? (WIDTH_BYTES - 1 - g) : g;
        assign rword[8*POS +: 8] = mem[base + CAW'(g)];
    end

endmodule

// File: rtl/nor_info_rom.sv
module nor_info_rom
    import nor_pkg::*;
#(
    parameter logic [7:0] MFR_ID       = 8'h01,
    parameter logic [7:0] DEV_ID       = 8'h7E,
    parameter int         CHIP_LOG2    = 7,
    parameter int         SECTORS      = 4,
    parameter int         SECTOR_BYTES = 32,
    parameter int         WIDTH_LOG2   = 1
) (
    input  logic [7:0] word_idx,
    output logic [7:0] id_byte,
    output logic [7:0] qry_byte
);

    always_comb begin
        case (word_idx)
            8'h00:   id_byte = MFR_ID;
            8'h01:   id_byte = DEV_ID;
            default: id_byte = 8'h00;
        endcase
        qry_byte = (word_idx < QUERY_LEN)
                 ? query_byte(word_idx, CHIP_LOG2, SECTORS, SECTOR_BYTES, WIDTH_LOG2)
                 : 8'h00;
    end

endmodule

// File: rtl/nor_flash_model.sv
module nor_flash_model
    import nor_pkg::*;
#(
    parameter int         WIDTH_BYTES      = 2,
    parameter int         SECTOR_BYTES     = 32,
    parameter int         SECTORS          = 4,
    parameter int         BUS_ADDR_W       = 8,
    parameter bit         BIG_ENDIAN       = 1'b0,
    parameter int         UNLOCK_A         = 5,
    parameter int         UNLOCK_B         = 10,
    parameter int         QUERY_ADDR       = 5,
    parameter logic [7:0] MFR_ID           = 8'h01,
    parameter logic [7:0] DEV_ID           = 8'h7E,
    parameter int         SECTOR_ERASE_CYC = 20,
    parameter int         CHIP_ERASE_CYC   = 200
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [BUS_ADDR_W-1:0]     addr,
    input  logic                      wr,
    input  logic                      rd,
    input  logic [8*WIDTH_BYTES-1:0]  wdata,
    output logic [8*WIDTH_BYTES-1:0]  rdata,
    output logic                      busy
);

    localparam int DW         = 8 * WIDTH_BYTES;
    localparam int CHIP_BYTES = SECTOR_BYTES * SECTORS;
    localparam int CAW        = $clog2(CHIP_BYTES);
    localparam int LANE_SH    = $clog2(WIDTH_BYTES);
    localparam int SWW        = $clog2(SECTOR_BYTES / WIDTH_BYTES);

    logic [CAW-1:0] chip_addr, word_full;
    logic [SWW-1:0] sect_word;
    seq_mode_e      mode;
    store_op_t      op;
    logic [7:0]     status, id_byte, qry_byte;
    logic [DW-1:0]  rword;

    assign chip_addr = addr[CAW-1:0];
    assign word_full = chip_addr >> LANE_SH;
    assign sect_word = word_full[SWW-1:0];

    nor_cmd_seq #(
        .SWW(SWW), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B), .QUERY_ADDR(QUERY_ADDR),
        .SECTOR_ERASE_CYC(SECTOR_ERASE_CYC), .CHIP_ERASE_CYC(CHIP_ERASE_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .wr(wr), .rd(rd), .cmd(wdata[7:0]),
        .sect_word(sect_word), .mode(mode), .op(op), .busy(busy), .status(status)
    );

    nor_store #(
        .WIDTH_BYTES(WIDTH_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
        .CHIP_BYTES(CHIP_BYTES), .BIG_ENDIAN(BIG_ENDIAN)
    ) u_store (
        .clk(clk), .rst(rst), .op(op), .chip_addr(chip_addr),
        .wdata(wdata), .rword(rword)
    );

    nor_info_rom #(
        .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .CHIP_LOG2(CAW), .SECTORS(SECTORS),
        .SECTOR_BYTES(SECTOR_BYTES), .WIDTH_LOG2(LANE_SH)
    ) u_rom (
        .word_idx(8'(word_full)), .id_byte(id_byte), .qry_byte(qry_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            case (mode)
                M_IDENT: rdata <= DW'(id_byte);
                M_QUERY: rdata <= DW'(qry_byte);
                M_BUSY:  rdata <= DW'(status);
                default: rdata <= rword;
            endcase
        end
    end

endmodule

// File: rtl/nor_flash_sva.sv
module nor_flash_sva #(
    parameter int DW               = 16,
    parameter int SECTOR_ERASE_CYC = 20,
    parameter int CHIP_ERASE_CYC   = 200
) (
    input logic          clk,
    input logic          rst,
    input logic          rd,
    input logic          wr,
    input logic          busy,
    input logic [DW-1:0] rdata
);

    logic [31:0] run;

    always_ff @(posedge clk) begin
        if (rst) run <= '0;
        else     run <= busy ? run + 32'd1 : 32'd0;
    end

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && rdata == '0));

    assert_rdata_held_R1: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

    assert_poll_bit7_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && rd) |=> (rdata[7] == 1'b0));

    assert_poll_toggle_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && rd && $past(busy && rd)) |=> (rdata[6] != $past(rdata[6])));

    assert_busy_length_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run == 32'(SECTOR_ERASE_CYC) || run == 32'(CHIP_ERASE_CYC)));

    assert_no_overlap_strobes_R2: assert property (@(posedge clk) disable iff (rst)
        !(rd && wr));

endmodule

bind nor_flash_model nor_flash_sva #(
    .DW(DW), .SECTOR_ERASE_CYC(SECTOR_ERASE_CYC), .CHIP_ERASE_CYC(CHIP_ERASE_CYC)
) u_sva (
    .clk(clk), .rst(rst), .rd(rd), .wr(wr), .busy(busy), .rdata(rdata)
);

// File: tb/tb_nor_flash_model.sv
module tb_nor_flash_model;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    nor_flash_model dut (
        .clk(clk), .rst(rst), .addr(addr), .wr(wr), .rd(rd),
        .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  mm [128];
    int          m_mode;
    bit          m_byp;
    int          m_cnt;
    logic [7:0]  m_st;
    logic [15:0] m_rdata;
    bit          m_rdv;
    int          ca, wi, sw, c, idle, bs;

    function automatic logic [7:0] qtab(input int i);
        case (i)
            16'h10:  return 8'h51;
            16'h11:  return 8'h52;
            16'h12:  return 8'h59;
            16'h27:  return 8'd7;
            16'h2D:  return 8'd3;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        m_rdv = 1'b0;
        if (rst) begin
            m_mode = 0; m_byp = 0; m_cnt = 0; m_st = 8'h00; m_rdata = '0;
            for (int k = 0; k < 128; k++) mm[k] = 8'hFF;
        end else begin
            ca = addr & 127; wi = ca >> 1; sw = wi & 15; c = wdata[7:0];
            idle = m_byp ? 2 : 0;
            bs = ca & ~1;
            if (rd) begin
                m_rdv = 1'b1;
                case (m_mode)
                    7: m_rdata = (wi == 0) ? 16'h01 : (wi == 1) ? 16'h7E : 16'h00;
                    8: m_rdata = {8'h00, qtab(wi)};
                    9: begin m_rdata = {8'h00, m_st}; m_st ^= 8'h40; end
                    default: m_rdata = {mm[bs + 1], mm[bs]};
                endcase
            end
            if (m_mode == 9) begin
                if (m_cnt == 1) m_mode = idle; else m_cnt--;
            end else if (wr) begin
                if (c == 8'hF0 && m_mode != 3) m_mode = idle;
                else case (m_mode)
                    0: if (sw == 5 && c == 8'h98) m_mode = 8;
                       else if (sw == 5 && c == 8'hAA) m_mode = 1;
                    1: m_mode = (sw == 10 && c == 8'h55) ? 2 : 0;
                    2: if (!m_byp && sw != 5) m_mode = idle;
                       else case (c)
                           8'hA0: m_mode = 3;
                           8'h80: m_mode = 4;
                           8'h90: m_mode = 7;
                           8'h20: begin m_byp = 1; m_mode = 2; end
                           default: m_mode = idle;
                       endcase
                    3: begin
                        mm[bs] &= wdata[7:0]; mm[bs + 1] &= wdata[15:8]; m_mode = idle;
                    end
                    4: m_mode = (sw == 5 && c == 8'hAA) ? 5 : idle;
                    5: m_mode = (sw == 10 && c == 8'h55) ? 6 : idle;
                    6: if (c == 8'h10 && sw == 5) begin
                           for (int k = 0; k < 128; k++) mm[k] = 8'hFF;
                           m_mode = 9; m_cnt = 200; m_st = 8'h00;
                       end else if (c == 8'h30) begin
                           for (int k = 0; k < 32; k++) mm[(ca & ~31) + k] = 8'hFF;
                           m_mode = 9; m_cnt = 20; m_st = 8'h00;
                       end else m_mode = idle;
                    7: if (m_byp && c == 0) begin m_byp = 0; m_mode = 0; end
                       else if (sw == 5 && c == 8'h98) m_mode = 8;
                       else m_mode = idle;
                    default: m_mode = idle;
                endcase
            end
        end
    end

    // per-cycle comparison and busy run length
    int busy_run = 0;
    int last_run = 0;
    always @(negedge clk) begin
        if (!rst) begin
            chk("R7", "busy vs model", int'(busy), int'(m_mode == 9));
            if (m_rdv) chk(cur_req, "rdata vs model", int'(rdata), int'(m_rdata));
            if (busy) busy_run++;
            else if (busy_run != 0) begin last_run = busy_run; busy_run = 0; end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL R7 watchdog expired actual=%0d expected<50000", cyc);
            report();
            $finish;
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; v = rdata;
    endtask

    task automatic unlock();
        bus_wr(8'h0A, 16'h00AA);
        bus_wr(8'h14, 16'h0055);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    logic [15:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "rdata after reset", int'(rdata), 0);
        chk("R1", "busy after reset", int'(busy), 0);
        bus_rd(8'h00, v); chk("R1", "erased array", v, 16'hFFFF);

        cur_req = "R3";
        unlock(); bus_wr(8'h0A, 16'h00A0); bus_wr(8'h04, 16'h1234);
        bus_rd(8'h04, v); chk("R3", "program lanes", v, 16'h1234);
        unlock(); bus_wr(8'h0A, 16'h00A0); bus_wr(8'h04, 16'hFF00);
        bus_rd(8'h04, v); chk("R3", "program ANDs", v, 16'h1200);

        cur_req = "R4";
        unlock(); bus_wr(8'h0A, 16'h00A0); bus_wr(8'h06, 16'h00F0);
        bus_rd(8'h06, v); chk("R4", "F0 as program data", v, 16'h00F0);
        unlock(); bus_wr(8'h0A, 16'h00F0); bus_wr(8'h0A, 16'h00A0); bus_wr(8'h0C, 16'h0000);
        bus_rd(8'h0C, v); chk("R4", "F0 aborts sequence", v, 16'hFFFF);

        cur_req = "R2";
        bus_wr(8'h0A, 16'h00AA); bus_wr(8'h16, 16'h0055);
        bus_wr(8'h0A, 16'h00A0); bus_wr(8'h08, 16'h0000);
        bus_rd(8'h08, v); chk("R2", "bad second unlock address", v, 16'hFFFF);
        unlock(); bus_wr(8'h02, 16'h00A0); bus_wr(8'h08, 16'h0000);
        bus_rd(8'h08, v); chk("R2", "command at wrong address", v, 16'hFFFF);

        cur_req = "R9";
        unlock(); bus_wr(8'h0A, 16'h0090);
        bus_rd(8'h00, v); chk("R9", "manufacturer id", v, 16'h0001);
        bus_rd(8'h02, v); chk("R9", "device id", v, 16'h007E);
        bus_rd(8'h04, v); chk("R9", "protection byte", v, 16'h0000);
        cur_req = "R10";
        bus_wr(8'h0A, 16'h0098);
        bus_rd(8'h20, v); chk("R10", "query Q from ident", v, 16'h0051);
        bus_wr(8'h00, 16'h00F0);
        bus_rd(8'h04, v); chk("R10", "back to array", v, 16'h1200);
        bus_wr(8'h0A, 16'h0098);
        bus_rd(8'h22, v); chk("R10", "query R", v, 16'h0052);
        bus_rd(8'h24, v); chk("R10", "query Y", v, 16'h0059);
        bus_rd(8'h4E, v); chk("R10", "chip size log2", v, 16'h0007);
        bus_rd(8'h5A, v); chk("R10", "sector count-1", v, 16'h0003);
        bus_rd(8'h6A, v); chk("R10", "past table end", v, 16'h0000);
        bus_wr(8'h00, 16'h0000);
        bus_rd(8'h04, v); chk("R10", "write leaves query", v, 16'h1200);

        cur_req = "R5";
        unlock(); bus_wr(8'h0A, 16'h00A0); bus_wr(8'h24, 16'h0000);
        unlock(); bus_wr(8'h0A, 16'h0080); unlock(); bus_wr(8'h2C, 16'h0030);
        cur_req = "R8";
        bus_rd(8'h24, v); chk("R8", "first poll", v, 16'h0000);
        bus_rd(8'h24, v); chk("R8", "second poll", v, 16'h0040);
        cur_req = "R7";
        unlock(); bus_wr(8'h0A, 16'h00A0); bus_wr(8'h04, 16'h0000);
        wait_idle();
        chk("R7", "sector erase busy length", last_run, 20);
        bus_rd(8'h04, v); chk("R7", "write during busy ignored", v, 16'h1200);
        bus_rd(8'h24, v); chk("R5", "sector erased", v, 16'hFFFF);

        cur_req = "R6";
        unlock(); bus_wr(8'h0A, 16'h0080); unlock(); bus_wr(8'h00, 16'h0010);
        @(negedge clk); chk("R6", "no busy on wrong address", int'(busy), 0);
        bus_rd(8'h04, v); chk("R6", "no erase on wrong address", v, 16'h1200);
        unlock(); bus_wr(8'h0A, 16'h0080); unlock(); bus_wr(8'h0A, 16'h0010);
        wait_idle();
        chk("R7", "chip erase busy length", last_run, 200);
        bus_rd(8'h04, v); chk("R6", "chip erased", v, 16'hFFFF);

        cur_req = "R11";
        unlock(); bus_wr(8'h0A, 16'h0020);
        bus_wr(8'h30, 16'h00A0); bus_wr(8'h30, 16'h5555);
        bus_rd(8'h30, v); chk("R11", "bypass program", v, 16'h5555);
        bus_wr(8'h30, 16'h0090); bus_wr(8'h30, 16'h0000);
        bus_wr(8'h30, 16'h00A0); bus_wr(8'h30, 16'h0000);
        bus_rd(8'h30, v); chk("R11", "bypass left", v, 16'h5555);

        cur_req = "R12";
        bus_wr(8'h8B, 16'h00AA); bus_wr(8'h94, 16'h0055); bus_wr(8'h8A, 16'h00A0);
        bus_wr(8'hC0, 16'h0F0F);
        bus_rd(8'h40, v); chk("R12", "wrapped program", v, 16'h0F0F);
        chk("R13", "odd byte of unlock word", v, 16'h0F0F);

        repeat (2) @(negedge clk);
        report();
        $finish;
    end

endmodule